// File: doc/BRIEF.md
# Folded Word Memory with Predecoded Wordlines

This block is a synthesizable model of a single-port, word-addressed memory. The storage is laid out the way a dense array is built, not as a flat list of words. The logical array of 2^(ROW_BITS+COL_BITS) words of WORD_W bits is folded into 2^ROW_BITS physical rows. Each row is WORD_W·2^COL_BITS bits wide. With the defaults, 2048 words of 16 bits sit in 256 rows of 128 bits.

The upper ROW_BITS address bits form the row field. The row field is split into pairs of bits. Each pair is predecoded into a group of four one-hot lines, and each wordline is the AND of one line from every group. The lower COL_BITS address bits form the column field. That field steers one multiplexer per data bit. Inside a row, the words are interleaved: bit b of word slot s sits at row column b·2^COL_BITS+s. Each bit's multiplexer therefore spans 2^COL_BITS adjacent columns.

Every selected access decodes one access kind: idle, read or write. A read loads the addressed word into a read register. A write merges the new word into its own columns of the addressed row and leaves the rest of the row alone. In the same cycle, the write loads the word's previous value into the read register. The wordline vector is a port of the block, so the decode can be watched from outside.

Top module: `folded_word_store`

## Requirements
- R1: While `cs` is high, exactly one bit of `wordline` is 1. It is the AND of one line from each predecoded four-line group.
- R2: The active wordline index equals the row field `addr[ADDR_W-1:COL_BITS]`. Addresses that differ only in the low COL_BITS bits select the same wordline.
- R3: A read (`cs`=1, `we`=0) presents the stored word of `addr` on `rd_data` after the next rising clock edge.
- R4: A write (`cs`=1, `we`=1) changes only the addressed word. The other words of the same row and of every other row keep their values.
- R5: A write loads the addressed word's value from before the write into `rd_data` at the same clock edge. A later read returns the new value.
- R6: While `cs` is low, `wordline` is all zero, no storage bit changes whatever `we`, `addr` and `wdata` carry, and `rd_data` holds its value.
- R7: A synchronous active-high `rst` clears `rd_data` to zero. The storage array is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the read register, active high |
| cs | input | 1 | Selects the memory for an access in this cycle |
| we | input | 1 | With `cs`, 1 = write and 0 = read |
| addr | input | ADDR_W (11) | Word address; the upper ROW_BITS bits select the row, the lower COL_BITS bits select the slot |
| wdata | input | WORD_W (16) | Word to store on a write |
| rd_data | output | WORD_W (16) | Registered read data |
| wordline | output | 2^ROW_BITS (256) | One-hot decoded row select, zero when idle |

## Verification
The bound checker watches the wordline vector on every cycle. It confirms that exactly one line is active during a selected access and that this line matches the row field of the address. It also confirms that no line is active when the memory is idle, that `rd_data` holds across idle cycles, and that reset clears it.

Some behaviours need the bench's scenarios instead. These are the interleaved column placement, the preservation of the neighbouring words in a row on a write, read-before-write data, and agreement with a flat word array under mixed traffic. The bench shows them by filling the whole address space, reading every word back, and running seeded random traffic against a reference array.

// File: rtl/fold_pkg.sv
package fold_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_t;

    function automatic access_t decode_access(input logic sel, input logic wr);
        if (!sel)
            return ACC_IDLE;
        else if (wr)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

endpackage

// File: rtl/row_predecoder.sv
module row_predecoder #(
    parameter int ROW_BITS = 8,
    localparam int GROUPS  = ROW_BITS / 2
) (
    input  logic [ROW_BITS-1:0] row_addr,
    input  logic                en,
    output logic [GROUPS*4-1:0] lines
);

    // Each pair of row-address bits becomes one 1-of-4 group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_pair
        assign lines[g*4 +: 4] = en ? (4'b0001 << row_addr[g*2 +: 2]) : 4'b0000;
    end

endmodule

// File: rtl/wordline_combiner.sv
module wordline_combiner #(
    parameter int ROW_BITS = 8,
    localparam int GROUPS  = ROW_BITS / 2,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic [GROUPS*4-1:0] lines,
    output logic [ROWS-1:0]     wordline
);

    // Row r takes, from group g, the line named by bits [2g+1:2g] of r.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_comb begin
            logic acc;
            acc = 1'b1;
            for (int g = 0; g < GROUPS; g++) begin
                acc = acc & lines[g*4 + ((r >> (2*g)) & 3)];
            end
            wordline[r] = acc;
        end
    end

endmodule

// File: rtl/column_mux.sv
module column_mux #(
    parameter int WORD_W   = 16,
    parameter int COL_BITS = 3,
    localparam int SLOTS   = 1 << COL_BITS,
    localparam int ROW_W   = WORD_W * SLOTS
) (
    input  logic [ROW_W-1:0]    row_q,
    input  logic [COL_BITS-1:0] sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   word_q,
    output logic [ROW_W-1:0]    row_d
);

    // Read side: one SLOTS:1 multiplexer per data bit over adjacent columns.
    for (genvar b = 0; b < WORD_W; b++) begin : g_rd
        logic [SLOTS-1:0] cols;
        assign cols      = row_q[b*SLOTS +: SLOTS];
        assign word_q[b] = cols[sel];
    end

    // Write side: only the selected slot's column inside each bit group takes new data.
    for (genvar j = 0; j < ROW_W; j++) begin : g_wr
        localparam int BIT  = j / SLOTS;
        localparam int SLOT = j % SLOTS;
        assign row_d[j] = (sel == COL_BITS'(SLOT)) ? wdata[BIT] : row_q[j];
    end

endmodule

// File: rtl/folded_word_store.sv
module folded_word_store #(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 3,
    parameter int WORD_W   = 16,
    localparam int ADDR_W  = ROW_BITS + COL_BITS,
    localparam int ROWS    = 1 << ROW_BITS,
    localparam int SLOTS   = 1 << COL_BITS,
    localparam int ROW_W   = WORD_W * SLOTS,
    localparam int GROUPS  = ROW_BITS / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic [ROWS-1:0]   wordline
);
    import fold_pkg::*;

    logic [ROW_W-1:0]    cells [ROWS];
    logic [GROUPS*4-1:0] pre_lines;
    logic [ROW_W-1:0]    row_q;
    logic [ROW_W-1:0]    row_d;
    logic [WORD_W-1:0]   word_q;
    access_t             acc;

    assign acc = decode_access(cs, we);

    row_predecoder #(.ROW_BITS(ROW_BITS)) i_predec (
        .row_addr (addr[ADDR_W-1:COL_BITS]),
        .en       (cs),
        .lines    (pre_lines)
    );

    wordline_combiner #(.ROW_BITS(ROW_BITS)) i_wl (
        .lines    (pre_lines),
        .wordline (wordline)
    );

    // The selected row is gathered through the wordlines, as a shared bitline would.
    always_comb begin
        row_q = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (wordline[r])
                row_q = row_q | cells[r];
        end
    end

    column_mux #(.WORD_W(WORD_W), .COL_BITS(COL_BITS)) i_col (
        .row_q  (row_q),
        .sel    (addr[COL_BITS-1:0]),
        .wdata  (wdata),
        .word_q (word_q),
        .row_d  (row_d)
    );

    // Array write: the merged row goes back only under the active wordline.
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (acc == ACC_WRITE && wordline[r])
                cells[r] <= row_d;
        end
    end

    // Read register: loads the addressed word's current contents on any access.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            unique case (acc)
                ACC_READ,
                ACC_WRITE: rd_data <= word_q;
                ACC_IDLE:  rd_data <= rd_data;
            endcase
        end
    end

endmodule

// File: rtl/fold_checks.sv
module fold_checks #(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 3,
    parameter int WORD_W   = 16,
    localparam int ADDR_W  = ROW_BITS + COL_BITS,
    localparam int ROWS    = 1 << ROW_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] rd_data,
    input logic [ROWS-1:0]   wordline
);

    p_wl_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        cs |-> $countones(wordline) == 1);

    p_wl_row_r2: assert property (@(posedge clk) disable iff (rst)
        cs |-> wordline[addr[ADDR_W-1:COL_BITS]]);

    p_wl_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !cs |-> wordline == '0);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cs |=> $stable(rd_data));

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> rd_data == '0);

endmodule

bind folded_word_store fold_checks #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .WORD_W   (WORD_W)
) i_checks (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .addr     (addr),
    .rd_data  (rd_data),
    .wordline (wordline)
);

// File: tb/test_folded_word_store.sv
module test_folded_word_store;
    localparam int ROW_BITS = 8;
    localparam int COL_BITS = 3;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = ROW_BITS + COL_BITS;
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int WORDS    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wdata = '0;
    logic [WORD_W-1:0] rd_data;
    logic [ROWS-1:0]   wordline;

    logic [WORD_W-1:0] ref_mem [WORDS];
    int total = 0;
    int bad = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    folded_word_store #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WORD_W(WORD_W))
        i_folded_word_store (
            .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
            .wdata(wdata), .rd_data(rd_data), .wordline(wordline));

    function automatic logic [WORD_W-1:0] pat(input int a);
        return WORD_W'((a * 40503) ^ 16'h5A3C);
    endfunction

    task automatic check(input string req, input logic [ROWS-1:0] act, input logic [ROWS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic access(input logic c, input logic w, input int a, input logic [WORD_W-1:0] d,
                          input logic chk_data, input logic [WORD_W-1:0] exp_data, input string req);
        logic [ROWS-1:0] exp_wl;
        cs = c; we = w; addr = ADDR_W'(a); wdata = d;
        #1;
        exp_wl = c ? (ROWS'(1) << (a >> COL_BITS)) : '0;
        check(c ? "R1/R2 wordline" : "R6 wordline idle", wordline, exp_wl);
        @(negedge clk);
        if (chk_data) check(req, ROWS'(rd_data), ROWS'(exp_data));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] held;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: read register cleared by reset, idle wordlines
        check("R7 reset rd_data", ROWS'(rd_data), '0);
        access(1'b0, 1'b0, 0, '0, 1'b1, '0, "R7/R6 rd_data after reset");

        // Fill every address (R1, R2 checked on each access)
        for (int a = 0; a < WORDS; a++) begin
            access(1'b1, 1'b1, a, pat(a), 1'b0, '0, "");
            ref_mem[a] = pat(a);
        end
        // R3: read every word back
        for (int a = 0; a < WORDS; a++)
            access(1'b1, 1'b0, a, '0, 1'b1, ref_mem[a], "R3 readback");

        // R4 and R5: write one slot of row 37, then read the whole row
        access(1'b1, 1'b1, 37*8+5, 16'hFFFF, 1'b1, ref_mem[37*8+5], "R5 old data on write");
        ref_mem[37*8+5] = 16'hFFFF;
        for (int s = 0; s < 8; s++)
            access(1'b1, 1'b0, 37*8+s, '0, 1'b1, ref_mem[37*8+s], "R4 row neighbours");
        access(1'b1, 1'b0, 36*8+5, '0, 1'b1, ref_mem[36*8+5], "R4 other row");
        access(1'b1, 1'b0, 38*8+5, '0, 1'b1, ref_mem[38*8+5], "R4 other row");

        // R6: an unselected write is ignored and rd_data holds
        held = rd_data;
        access(1'b0, 1'b1, 100, ~ref_mem[100], 1'b1, held, "R6 rd_data hold");
        access(1'b0, 1'b0, 101, '0, 1'b1, held, "R6 rd_data hold");
        access(1'b1, 1'b0, 100, '0, 1'b1, ref_mem[100], "R6 no write when idle");

        // R3, R4, R5: seeded random traffic against the flat reference array
        for (int n = 0; n < 4000; n++) begin
            int a;
            logic [WORD_W-1:0] d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = int'(lfsr[ADDR_W-1:0]);
            d = lfsr[27:12];
            if (lfsr[29:28] == 2'b00) begin
                access(1'b0, lfsr[30], a, d, 1'b1, rd_data, "R6 random idle");
            end else if (lfsr[30]) begin
                access(1'b1, 1'b1, a, d, 1'b1, ref_mem[a], "R5 random write old data");
                ref_mem[a] = d;
            end else begin
                access(1'b1, 1'b0, a, '0, 1'b1, ref_mem[a], "R3 random read");
            end
        end

        // R7: reset clears the read register but keeps storage
        cs = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 rd_data cleared", ROWS'(rd_data), '0);
        access(1'b1, 1'b0, 37*8+5, '0, 1'b1, ref_mem[37*8+5], "R7 storage kept");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule